// File: doc/BRIEF.md
# Distributed Priority Bus Arbiter

This block holds the per-device controllers of a synchronous shared bus on which four devices decide among themselves who drives the bus next. No central arbiter exists. Each controller drives one bus request line, watches every request line on the bus, and works out locally whether it owns the bus in the next cycle. Each bus transfer lasts exactly one clock cycle. A device that has just been master must sit out the following cycle, even when it has the highest priority.

The top level places one controller per device. Bit k of every vector belongs to the device with priority k+1, so bit 3 is the highest priority. Each controller is a clocked Moore machine with three states: idle, waiting and owner. Its request-line output is high only while it waits. Its master output is high only while it owns the bus. Because an owner never drives its request line, the other controllers disregard the current owner when they compare priorities. When the owner sits out, the next-highest waiting device wins that cycle. Devices of low priority can still starve while two devices of higher priority keep asking. All pins are plain control pins, so there is no valid/ready handshake and no back-pressure.

Top module: `dbus_arbiter_top`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, every bit of bus_req and bus_master is 0.
- R2: If device k is neither waiting nor master and dev_want[k] is 1 at a clock edge, bus_req[k] is 1 in the following cycle.
- R3: Once bus_req[k] is 1, it stays 1 on every later edge until the edge where bus_master[k] becomes 1. On that edge bus_req[k] falls to 0.
- R4: At each edge, the waiting device with the highest bit index becomes master for the next cycle. A device becomes master only if it was waiting in the cycle before.
- R5: A device is master for exactly one cycle and is never master in two consecutive cycles.
- R6: At most one bit of bus_master is 1 in any cycle.
- R7: If any bus_req bit is 1 in a cycle, some bus_master bit is 1 in the next cycle.
- R8: When a device leaves the master state, bus_req[k] is 1 in the next cycle if dev_want[k] was 1 at that edge, and 0 otherwise.
- R9: While devices 3 and 2 (the two highest bits) keep dev_want high, mastership alternates between them every cycle, and devices 1 and 0 are never served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all transitions happen on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_want | input | N_DEV | Local wish of each device to use the bus; bit k is priority k+1 |
| bus_req | output | N_DEV | Bus request lines, one driven by each controller |
| bus_master | output | N_DEV | One-cycle master indication per device |

## Verification
On every cycle the assertions check that there is at most one master, that no device is master twice in a row, that a pending request is held until it is served, that every master was a requester the cycle before, and that a bus with pending requests never stays masterless. Which device wins, and the alternation that starves the two low-priority devices, can only be shown by the bench's scenarios. The bench compares both output vectors against a reference computed from the requirements, using directed patterns and seeded random wishes.

// File: rtl/dbus_pkg.sv
package dbus_pkg;
  typedef enum logic [1:0] {
    NODE_IDLE  = 2'd0,
    NODE_WAIT  = 2'd1,
    NODE_OWNER = 2'd2
  } node_state_t;
endpackage

// File: rtl/dbus_higher_seen.sv
// Reports whether any request line above position SELF is asserted.
module dbus_higher_seen #(
  parameter int N_DEV = 4,
  parameter int SELF  = 0
) (
  input  logic [N_DEV-1:0] lines,
  output logic             higher
);
  localparam int ABOVE = N_DEV - 1 - SELF;

  generate
    if (ABOVE == 0) begin : g_top
      assign higher = 1'b0;
    end else begin : g_rest
      assign higher = |lines[N_DEV-1:SELF+1];
    end
  endgenerate
endmodule

// File: rtl/dbus_node.sv
// One device controller: Moore machine with idle / waiting / owner states.
module dbus_node
  import dbus_pkg::*;
#(
  parameter int N_DEV = 4,
  parameter int SELF  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             want,
  input  logic [N_DEV-1:0] lines_in,
  output logic             line_out,
  output logic             owner
);
  node_state_t state_q, state_d;
  logic        blocked;

  dbus_higher_seen #(.N_DEV(N_DEV), .SELF(SELF)) u_seen (
    .lines  (lines_in),
    .higher (blocked)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      NODE_IDLE:  if (want) state_d = NODE_WAIT;
      NODE_WAIT:  if (!blocked) state_d = NODE_OWNER;
      NODE_OWNER: state_d = want ? NODE_WAIT : NODE_IDLE;
      default:    state_d = NODE_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= NODE_IDLE;
    else        state_q <= state_d;
  end

  assign line_out = (state_q == NODE_WAIT);
  assign owner    = (state_q == NODE_OWNER);
endmodule

// File: rtl/dbus_arbiter_top.sv
module dbus_arbiter_top #(
  parameter int N_DEV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] dev_want,
  output logic [N_DEV-1:0] bus_req,
  output logic [N_DEV-1:0] bus_master
);
  generate
    for (genvar k = 0; k < N_DEV; k++) begin : g_node
      dbus_node #(.N_DEV(N_DEV), .SELF(k)) u_node (
        .clk      (clk),
        .rst_n    (rst_n),
        .want     (dev_want[k]),
        .lines_in (bus_req),
        .line_out (bus_req[k]),
        .owner    (bus_master[k])
      );
    end
  endgenerate
endmodule

// File: rtl/dbus_arbiter_chk.sv
module dbus_arbiter_chk #(
  parameter int N_DEV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_DEV-1:0] dev_want,
  input logic [N_DEV-1:0] bus_req,
  input logic [N_DEV-1:0] bus_master
);
  assert_one_master_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(bus_master));

  assert_busy_served_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|bus_req) |=> (|bus_master));

  generate
    for (genvar k = 0; k < N_DEV; k++) begin : g_dev
      assert_no_repeat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_master[k] |=> !bus_master[k]);

      assert_req_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req[k] |=> (bus_req[k] || bus_master[k]));

      assert_master_from_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_master[k]) |-> $past(bus_req[k]));

      assert_want_raises_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_want[k] && !bus_req[k] && !bus_master[k]) |=> bus_req[k]);

      assert_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_master[k] |=> (bus_req[k] == $past(dev_want[k])));
    end
  endgenerate
endmodule

bind dbus_arbiter_top dbus_arbiter_chk #(.N_DEV(N_DEV)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dev_want   (dev_want),
  .bus_req    (bus_req),
  .bus_master (bus_master)
);

// File: tb/dbus_arbiter_top_test.sv
module dbus_arbiter_top_test;
  localparam int N = 4;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] dev_want = '0;
  logic [N-1:0] bus_req;
  logic [N-1:0] bus_master;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  logic [N-1:0] m_req = '0;
  logic [N-1:0] m_mst = '0;

  dbus_arbiter_top #(.N_DEV(N)) uut (
    .clk(clk), .rst_n(rst_n), .dev_want(dev_want),
    .bus_req(bus_req), .bus_master(bus_master)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference winner per R4: highest-index waiting device
  function automatic logic [N-1:0] pick_winner(logic [N-1:0] req);
    logic [N-1:0] w = '0;
    for (int i = N-1; i >= 0; i--)
      if (req[i]) begin w[i] = 1'b1; break; end
    return w;
  endfunction

  // Reference next request lines per R2, R3, R8
  function automatic logic [N-1:0] next_req(logic [N-1:0] req, logic [N-1:0] want);
    logic [N-1:0] w = pick_winner(req);
    logic [N-1:0] r;
    for (int i = 0; i < N; i++)
      r[i] = req[i] ? !w[i] : want[i];
    return r;
  endfunction

  task automatic check(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  // One cycle: drive want at negedge, step model at posedge, compare at next negedge
  task automatic cycle(logic [N-1:0] w);
    dev_want = w;
    @(posedge clk);
    m_mst = pick_winner(m_req);
    m_req = next_req(m_req, w);
    @(negedge clk);
    check("R4 bus_master vs model", bus_master, m_mst);
    check("R3 bus_req vs model", bus_req, m_req);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    dev_want = '0;
    repeat (2) @(negedge clk);
    check("R1 bus_req in reset", bus_req, '0);
    check("R1 bus_master in reset", bus_master, '0);
    rst_n = 1'b1;
    m_req = '0;
    m_mst = '0;
    @(negedge clk);
    check("R1 bus_req after reset", bus_req, '0);
    check("R1 bus_master after reset", bus_master, '0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    do_reset();

    // Single requester, lowest priority: latency and exit to idle (R2, R4, R8)
    cycle(4'b0001);
    check("R2 request raised", bus_req, 4'b0001);
    cycle(4'b0000);
    check("R4 sole requester wins", bus_master, 4'b0001);
    check("R4 request dropped on grant", bus_req, 4'b0000);
    cycle(4'b0000);
    check("R8 owner without wish goes idle", bus_req | bus_master, 4'b0000);

    // Two requesters: priority order (R4, R3)
    cycle(4'b0101);
    cycle(4'b0000);
    check("R4 higher index wins", bus_master, 4'b0100);
    check("R3 loser still waiting", bus_req, 4'b0001);
    cycle(4'b0000);
    check("R7 loser served next", bus_master, 4'b0001);
    cycle(4'b0000);

    // Highest device keeps wishing alone: sits out every other cycle (R5, R8)
    cycle(4'b1000);
    cycle(4'b1000);
    check("R4 top device master", bus_master, 4'b1000);
    cycle(4'b1000);
    check("R5 not master twice", bus_master, 4'b0000);
    check("R8 owner with wish requests again", bus_req, 4'b1000);
    cycle(4'b0000);
    cycle(4'b0000);

    // Starvation: everyone keeps wishing (R9)
    begin
      logic [N-1:0] prev = '0;
      cycle(4'b1111);
      for (int c = 0; c < 24; c++) begin
        cycle(4'b1111);
        check("R6 single master", {3'b0, $countones(bus_master) <= 1} , 4'b0001);
        check("R9 low devices starved", bus_master & 4'b0011, 4'b0000);
        if (c > 0) check("R9 alternation", bus_master, ~prev & 4'b1100);
        prev = bus_master;
      end
    end

    do_reset();

    // Seeded random wishes against the reference model
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] w;
      w = N'($urandom_range(0, (1 << N) - 1));
      if (($urandom % 4) == 0) w = '0;
      cycle(w);
    end
    repeat (8) cycle('0);
    check("R7 bus drains to idle", bus_req | bus_master, '0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule